// File: doc/BRIEF.md
# Receive timestamp inserter

This block sits on a byte-wide receive stream (one byte per valid beat, with start-of-frame and end-of-frame strobes) and writes the arrival time of precision time protocol event messages into the frame itself. When a frame starts, the block latches a compact 32-bit arrival stamp from the local time-of-day inputs. The stamp holds the two lowest seconds bits and a 30-bit nanoseconds value. Software that later reads the frame rebuilds the full time from this stamp and its own coarse clock.

A frame is treated as a layer-2 PTP frame when frame bytes 12 and 13 carry EtherType 0x88F7. The PTP header then starts at frame byte 14. If the message is an event type enabled by the filter, the block is not bypassed, and the insertion mode selects in-place stamping, the four reserved bytes at header offsets 16 to 19 (frame bytes 30 to 33) are replaced by the stamp. Every other byte, and every other frame, passes through unchanged. All traffic goes through a single register stage, so latency is the same whether or not a frame is stamped. The block does not recompute the FCS or any checksum.

The configuration inputs are sampled on the beat that carries PTP header byte 0 (frame byte 14). A new start-of-frame strobe always restarts the byte count, even if the previous frame had no end strobe.

Top module: `rx_ts_inserter`

## Requirements
- R1: While reset is held and on the first edge after it, out_valid, out_sof and out_eof are 0 and out_data is 0x00.
- R2: Every output (out_valid, out_data, out_sof, out_eof) shows the input beat of the previous clock cycle, idle cycles included, with no extra delay for stamped frames.
- R3: A frame whose bytes 12 and 13 are not 0x88 then 0xF7 leaves the block byte for byte unchanged.
- R4: In a stamped frame, frame bytes 30, 31, 32 and 33 carry stamp bits 31:24, 23:16, 15:8 and 7:0 (big-endian), and all other bytes are unchanged.
- R5: The stamp holds tod_sec_lo in bits 31:30 and tod_nsec in bits 29:0, both sampled on the beat that carries in_sof.
- R6: A frame is stamped only when cfg_ins_mode equals 2; any other mode value leaves PTP frames unchanged.
- R7: The message type is the low nibble of frame byte 14. Types 0 to 3 are event types, and type n is stamped only when cfg_evt_filter bit n is 1 (0xF stamps all event types, 0x0 stamps none). Types 4 to 15 are never stamped.
- R8: With cfg_bypass at 1, PTP frames pass unchanged whatever the mode and filter are.
- R9: A frame that ends before byte 30 is unchanged. When a start-of-frame strobe arrives before the end strobe of the current frame, the byte count starts again at 0 for the new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of frame (qualified by in_valid) |
| in_eof | input | 1 | Last byte of frame (qualified by in_valid) |
| cfg_bypass | input | 1 | 1 disables all timestamp processing |
| cfg_ins_mode | input | 3 | Insertion mode; 2 enables in-place stamping |
| cfg_evt_filter | input | 4 | Bit n enables stamping of event message type n |
| tod_sec_lo | input | 2 | Low two bits of the time-of-day seconds |
| tod_nsec | input | 30 | Time-of-day nanoseconds |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte, possibly replaced by a stamp byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |

## Verification
Each output beat is due exactly one clock cycle after the input beat that produced it. The bench samples 2 ns after every rising edge and compares out_valid, out_sof and out_eof with the beat the bench drove in the same cycle, so a missing or extra register shows up as a mismatch. The stamp is due at output bytes 30 to 33. The bench computes it from the time values it drove on the start-of-frame beat and checks it against the captured bytes once the frame has fully drained. Idle gaps are inserted at random inside frames, so the one-cycle timing is checked on non-consecutive beats as well.

// File: rtl/rx_ts_pkg.sv
package rx_ts_pkg;

  localparam int STAMP_W  = 32;
  localparam int NSEC_W   = 30;
  localparam int SECLO_W  = STAMP_W - NSEC_W;
  localparam int FILT_W   = 4;

  // Pack the compact arrival stamp: seconds low bits on top, nanoseconds below.
  function automatic logic [STAMP_W-1:0] pack_stamp(input logic [SECLO_W-1:0] sec_lo,
                                                    input logic [NSEC_W-1:0]  nsec);
    return {sec_lo, nsec};
  endfunction

  // Byte lane of the stamp in wire order: lane 0 is the most significant byte.
  function automatic logic [7:0] stamp_lane(input logic [STAMP_W-1:0] word,
                                            input logic [1:0]         lane);
    logic [7:0] b;
    case (lane)
      2'd0:    b = word[31:24];
      2'd1:    b = word[23:16];
      2'd2:    b = word[15:8];
      default: b = word[7:0];
    endcase
    return b;
  endfunction

  // An event message is type 0..3; it is stamped if its filter bit is set.
  function automatic logic event_selected(input logic [3:0]        msg_type,
                                          input logic [FILT_W-1:0] filt);
    return (msg_type[3:2] == 2'b00) && filt[msg_type[1:0]];
  endfunction

endpackage

// File: rtl/rx_ts_frame_parser.sv
module rx_ts_frame_parser
  import rx_ts_pkg::*;
#(
  parameter int          IDX_W    = 6,
  parameter logic [15:0] ETYPE    = 16'h88F7,
  parameter int          HDR_OFS  = 14,
  parameter int          RSV_OFS  = 16,
  parameter int          MODE_W   = 3,
  parameter int          INS_MODE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [7:0]        in_data,
  input  logic              cfg_bypass,
  input  logic [MODE_W-1:0] cfg_ins_mode,
  input  logic [FILT_W-1:0] cfg_evt_filter,
  output logic              repl_now,
  output logic [1:0]        repl_lane
);

  localparam logic [IDX_W-1:0] IDX_ET_HI  = IDX_W'(HDR_OFS - 2);
  localparam logic [IDX_W-1:0] IDX_ET_LO  = IDX_W'(HDR_OFS - 1);
  localparam logic [IDX_W-1:0] IDX_HDR0   = IDX_W'(HDR_OFS);
  localparam logic [IDX_W-1:0] IDX_RSV_LO = IDX_W'(HDR_OFS + RSV_OFS);
  localparam logic [IDX_W-1:0] IDX_RSV_HI = IDX_W'(HDR_OFS + RSV_OFS + 3);
  localparam logic [IDX_W-1:0] IDX_SAT    = '1;

  logic [IDX_W-1:0] beat_cnt;
  logic [IDX_W-1:0] cur_idx;
  logic [7:0]       etype_hi;
  logic             etype_ok;
  logic             stamp_en;
  logic             in_window;

  // Byte position of the current beat; a start strobe forces position 0.
  assign cur_idx   = in_sof ? '0 : beat_cnt;
  assign in_window = (cur_idx >= IDX_RSV_LO) && (cur_idx <= IDX_RSV_HI);
  assign repl_now  = in_valid && stamp_en && in_window;
  assign repl_lane = 2'(cur_idx - IDX_RSV_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt <= '0;
    end else if (in_valid) begin
      beat_cnt <= (cur_idx == IDX_SAT) ? cur_idx : cur_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      etype_hi <= '0;
      etype_ok <= 1'b0;
      stamp_en <= 1'b0;
    end else if (in_valid) begin
      if (in_sof) begin
        etype_ok <= 1'b0;
        stamp_en <= 1'b0;
      end
      if (cur_idx == IDX_ET_HI) etype_hi <= in_data;
      if (cur_idx == IDX_ET_LO) etype_ok <= ({etype_hi, in_data} == ETYPE);
      if (cur_idx == IDX_HDR0) begin
        stamp_en <= etype_ok && !cfg_bypass &&
                    (cfg_ins_mode == MODE_W'(INS_MODE)) &&
                    event_selected(in_data[3:0], cfg_evt_filter);
      end
    end
  end

  // Stamping can only be armed under insertion mode without bypass.
  assert_arm_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stamp_en) |-> ($past(cfg_ins_mode) == MODE_W'(INS_MODE)) && !$past(cfg_bypass));

  // Bypass never lets stamping arm.
  assert_arm_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_bypass) |-> !$rose(stamp_en));

  // Only an enabled event type arms stamping.
  assert_arm_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stamp_en) |-> ($past(in_data[3:2]) == 2'b00) && $past(etype_ok));

  // Replacement never happens on a start beat.
  assert_repl_not_sof_R9: assert property (@(posedge clk) disable iff (!rst_n)
    repl_now |-> !in_sof);

endmodule

// File: rtl/rx_ts_stamp_latch.sv
module rx_ts_stamp_latch
  import rx_ts_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [SECLO_W-1:0] tod_sec_lo,
  input  logic [NSEC_W-1:0]  tod_nsec,
  output logic [STAMP_W-1:0] stamp_word
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp_word <= '0;
    end else if (capture) begin
      stamp_word <= pack_stamp(tod_sec_lo, tod_nsec);
    end
  end

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (stamp_word[31:30] == $past(tod_sec_lo)) && (stamp_word[29:0] == $past(tod_nsec)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(stamp_word));

endmodule

// File: rtl/rx_ts_out_stage.sv
module rx_ts_out_stage
  import rx_ts_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic [7:0]         in_data,
  input  logic               repl_now,
  input  logic [1:0]         repl_lane,
  input  logic [STAMP_W-1:0] stamp_word,
  output logic               out_valid,
  output logic               out_sof,
  output logic               out_eof,
  output logic [7:0]         out_data
);

  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_data  <= '0;
      armed     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_sof   <= in_valid && in_sof;
      out_eof   <= in_valid && in_eof;
      out_data  <= repl_now ? stamp_lane(stamp_word, repl_lane) : in_data;
      armed     <= 1'b1;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid)) && (out_sof == $past(in_valid && in_sof)));

  assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(repl_now)) |-> (out_data == $past(in_data)));

  assert_reset_R1: assert property (@(posedge clk)
    !armed |-> !out_valid && !out_sof && !out_eof);

endmodule

// File: rtl/rx_ts_inserter.sv
module rx_ts_inserter
  import rx_ts_pkg::*;
#(
  parameter logic [15:0] ETYPE    = 16'h88F7,
  parameter int          HDR_OFS  = 14,
  parameter int          RSV_OFS  = 16,
  parameter int          MODE_W   = 3,
  parameter int          INS_MODE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic               cfg_bypass,
  input  logic [MODE_W-1:0]  cfg_ins_mode,
  input  logic [FILT_W-1:0]  cfg_evt_filter,
  input  logic [SECLO_W-1:0] tod_sec_lo,
  input  logic [NSEC_W-1:0]  tod_nsec,
  output logic               out_valid,
  output logic [7:0]         out_data,
  output logic               out_sof,
  output logic               out_eof
);

  localparam int LAST_BYTE = HDR_OFS + RSV_OFS + 3;
  localparam int IDX_W     = $clog2(LAST_BYTE + 2);

  logic               repl_now;
  logic [1:0]         repl_lane;
  logic [STAMP_W-1:0] stamp_word;
  logic               sof_beat;

  assign sof_beat = in_valid && in_sof;

  rx_ts_frame_parser #(
    .IDX_W   (IDX_W),
    .ETYPE   (ETYPE),
    .HDR_OFS (HDR_OFS),
    .RSV_OFS (RSV_OFS),
    .MODE_W  (MODE_W),
    .INS_MODE(INS_MODE)
  ) u_parser (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_sof        (in_sof),
    .in_data       (in_data),
    .cfg_bypass    (cfg_bypass),
    .cfg_ins_mode  (cfg_ins_mode),
    .cfg_evt_filter(cfg_evt_filter),
    .repl_now      (repl_now),
    .repl_lane     (repl_lane)
  );

  rx_ts_stamp_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (sof_beat),
    .tod_sec_lo(tod_sec_lo),
    .tod_nsec  (tod_nsec),
    .stamp_word(stamp_word)
  );

  rx_ts_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .in_data   (in_data),
    .repl_now  (repl_now),
    .repl_lane (repl_lane),
    .stamp_word(stamp_word),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_data  (out_data)
  );

  // Replacement lanes step in order 0..3 across consecutive stamped beats.
  assert_lane_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (repl_now && repl_lane != 2'd0) |-> ($past(repl_lane) == repl_lane - 2'd1) || !$past(in_valid));

endmodule

// File: tb/rx_ts_inserter_tb.sv
module rx_ts_inserter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        cfg_bypass = 1'b0;
  logic [2:0]  cfg_ins_mode = 3'd2;
  logic [3:0]  cfg_evt_filter = 4'hF;
  logic [31:0] sec_c = 32'h1234_567D;
  logic [29:0] ns_c = 30'd999_999_000;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_sof;
  logic        out_eof;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] fr [0:127];
  logic [7:0] cap [0:127];
  int cap_n = 0;
  int lat_err = 0;
  bit mon_on = 1'b0;
  logic [31:0] exp_stamp;

  always #4 clk = ~clk;

  rx_ts_inserter u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .cfg_bypass(cfg_bypass), .cfg_ins_mode(cfg_ins_mode), .cfg_evt_filter(cfg_evt_filter),
    .tod_sec_lo(sec_c[1:0]), .tod_nsec(ns_c),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof)
  );

  // Local time of day advances just after each rising edge.
  always begin
    @(posedge clk); #1;
    if (ns_c >= 30'd999_999_992) begin
      ns_c  = ns_c + 30'd8 - 30'd1_000_000_000;
      sec_c = sec_c + 1;
    end else begin
      ns_c = ns_c + 30'd8;
    end
  end

  // Output monitor, 2 ns after each rising edge.
  always begin
    @(posedge clk); #2;
    if (mon_on) begin
      if (out_valid !== in_valid ||
          (in_valid && (out_sof !== in_sof || out_eof !== in_eof)) ||
          (!in_valid && (out_sof !== 1'b0 || out_eof !== 1'b0)))
        lat_err++;
      if (out_valid && cap_n < 128) begin
        cap[cap_n] = out_data;
        cap_n++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  function automatic bit bench_stamp_on(input int len, input logic [2:0] mode,
                                        input logic [3:0] filt, input bit byp);
    logic [3:0] mt;
    if (len <= 14 || byp || mode != 3'd2) return 1'b0;
    if (fr[12] != 8'h88 || fr[13] != 8'hF7) return 1'b0;
    mt = fr[14][3:0];
    if (mt > 4'd3) return 1'b0;
    return filt[mt];
  endfunction

  function automatic logic [7:0] bench_exp(input int idx, input bit on, input logic [31:0] w);
    if (on && idx >= 30 && idx <= 33) return w[8*(33-idx) +: 8];
    return fr[idx];
  endfunction

  function automatic string pick_req(input int len, input logic [2:0] mode,
                                     input logic [3:0] filt, input bit byp, input bit on);
    if (on) return "R4";
    if (len <= 30) return "R9";
    if (fr[12] != 8'h88 || fr[13] != 8'hF7) return "R3";
    if (byp) return "R8";
    if (mode != 3'd2) return "R6";
    return "R7";
  endfunction

  task automatic build(input int len, input bit ptp, input logic [3:0] mt);
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    if (len > 13) begin
      if (ptp) begin fr[12] = 8'h88; fr[13] = 8'hF7; end
      else     begin fr[12] = 8'h08; fr[13] = 8'h00; end
    end
    if (len > 14) fr[14] = {4'($urandom), mt};
  endtask

  task automatic drive(input int len, input int gap_pct, input bit with_eof);
    for (int i = 0; i < len; i++) begin
      if (i != 0 && int'($urandom % 100) < gap_pct) begin
        @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = fr[i];
      in_sof = (i == 0); in_eof = with_eof && (i == len - 1);
      if (i == 0) exp_stamp = {sec_c[1:0], ns_c};
    end
    @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic run_frame(input int len, input int gap_pct, input logic [2:0] mode,
                           input logic [3:0] filt, input bit byp);
    bit on;
    int mism, first;
    string req;
    @(negedge clk);
    cfg_ins_mode = mode; cfg_evt_filter = filt; cfg_bypass = byp;
    cap_n = 0; lat_err = 0;
    drive(len, gap_pct, 1'b1);
    repeat (3) @(negedge clk);
    on = bench_stamp_on(len, mode, filt, byp);
    req = pick_req(len, mode, filt, byp, on);
    chk(cap_n == len, "R2", "byte count", cap_n, len);
    chk(lat_err == 0, "R2", "one-cycle timing errors", lat_err, 0);
    mism = 0; first = 0;
    for (int i = 0; i < len && i < cap_n; i++)
      if (cap[i] !== bench_exp(i, on, exp_stamp)) begin
        if (mism == 0) first = i;
        mism++;
      end
    chk(mism == 0, req, $sformatf("first bad byte %0d", first),
        int'(cap[first]), int'(bench_exp(first, on, exp_stamp)));
    if (on && len >= 34)
      chk({cap[30], cap[31], cap[32], cap[33]} == exp_stamp, "R5", "stamp word",
          int'({cap[30], cap[31], cap[32], cap[33]}), int'(exp_stamp));
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (5) @(negedge clk);
    chk(out_valid === 1'b0 && out_sof === 1'b0 && out_eof === 1'b0, "R1",
        "flags in reset", {out_valid, out_sof, out_eof}, 0);
    chk(out_data === 8'h00, "R1", "data in reset", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && out_data === 8'h00, "R1", "after release",
        {out_valid, out_data}, 0);
    mon_on = 1'b1;

    // Directed: stamped event types (R4, R5), seconds wrap region
    build(60, 1'b1, 4'd0); run_frame(60, 0, 3'd2, 4'hF, 1'b0);
    build(40, 1'b1, 4'd3); run_frame(40, 30, 3'd2, 4'h8, 1'b0);
    // Filter excludes type 3; general type 8 never stamped (R7)
    build(40, 1'b1, 4'd3); run_frame(40, 0, 3'd2, 4'h7, 1'b0);
    build(40, 1'b1, 4'd8); run_frame(40, 0, 3'd2, 4'hF, 1'b0);
    build(40, 1'b1, 4'd1); run_frame(40, 0, 3'd2, 4'h0, 1'b0);
    // Mode other than 2 (R6)
    build(40, 1'b1, 4'd1); run_frame(40, 0, 3'd1, 4'hF, 1'b0);
    build(40, 1'b1, 4'd2); run_frame(40, 0, 3'd3, 4'hF, 1'b0);
    // Bypass (R8)
    build(40, 1'b1, 4'd0); run_frame(40, 20, 3'd2, 4'hF, 1'b1);
    // Non-PTP EtherType (R3)
    build(50, 1'b0, 4'd0); run_frame(50, 0, 3'd2, 4'hF, 1'b0);
    // Short frames (R9): 20 bytes unchanged, 32 bytes partially stamped
    build(20, 1'b1, 4'd0); run_frame(20, 0, 3'd2, 4'hF, 1'b0);
    build(32, 1'b1, 4'd0); run_frame(32, 0, 3'd2, 4'hF, 1'b0);

    // R9: truncated frame without end strobe, then a new start restarts the count
    build(22, 1'b1, 4'd0);
    @(negedge clk); cfg_ins_mode = 3'd2; cfg_evt_filter = 4'hF; cfg_bypass = 1'b0;
    drive(22, 0, 1'b0);
    build(40, 1'b1, 4'd2); run_frame(40, 0, 3'd2, 4'hF, 1'b0);

    // Constrained random mix
    for (int k = 0; k < 40; k++) begin
      int len;
      bit ptp;
      logic [3:0] mt;
      logic [2:0] md;
      len = 28 + int'($urandom % 45);
      ptp = ($urandom % 4) != 0;
      mt  = ($urandom % 3 == 0) ? 4'($urandom) : 4'($urandom % 4);
      md  = ($urandom % 4 == 0) ? 3'($urandom) : 3'd2;
      build(len, ptp, mt);
      run_frame(len, int'($urandom % 40), md, 4'($urandom), ($urandom % 8) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule